// File: doc/BRIEF.md
# Key-Locked Pin-Mux Configuration Bank

This block holds the pin-multiplexing selections of a chip in a bank of eight 32-bit configuration words and drives them out as one wide parallel bus to the pad logic. Stray software writes must not alter the pad routing, so the bank refuses every configuration write until software has performed a two-step unlock. The first step writes a fixed 32-bit key to one kick register. The second step writes a different fixed key to a second kick register. Any reset puts the bank back under lock.

Software reaches the bank through a plain single-cycle register port. The port carries a word address, write data, a write strobe, a privilege flag and combinational read data. A small sequencer tracks the unlock progress in three named states. **LOCKED** is the reset state. **ARMED** means the first key has been seen but the bank is still locked. **OPEN** means configuration writes take effect.

The transitions are these. *arm* (LOCKED→ARMED, and OPEN→ARMED) fires on the correct first key. *open* (ARMED→OPEN) fires on the correct second key. *relock* (ARMED→LOCKED, OPEN→LOCKED) fires on a wrong value written to either kick register. *hold* covers all other cycles, and reset forces LOCKED.

Top module: `pinmux_keylock_bank`

## Requirements
- R1: After reset the sequencer is LOCKED. All eight configuration words read 0, the mux output bus is 0, and the status word (address 10) reads 0x1.
- R2: While the state is LOCKED or ARMED, privileged writes to configuration addresses 0 to 7 leave every stored word and the mux output unchanged.
- R3: A privileged write of 0x83E70B13 to the first kick register (address 8) from LOCKED enters ARMED. The status reads 0x3, where bit 0 is the locked flag and bit 1 is the first-key-pending flag, and configuration writes are still discarded.
- R4: A privileged write of 0x95A4F1E0 to the second kick register (address 9) while ARMED enters OPEN, and the status reads 0x0. From then on, a privileged write to address i stores the data, and the data is readable and on the output from the next cycle.
- R5: A second-key write that is not preceded by a correct first-key write leaves the bank LOCKED.
- R6: Any other value written to address 8, in any state, returns to LOCKED and clears the pending flag. A following correct second key does not unlock the bank.
- R7: A wrong value written to address 9 while ARMED or OPEN returns to LOCKED.
- R8: A write with the privilege flag low changes neither the lock state nor any configuration word, whatever its address or data.
- R9: Configuration words are readable in every state. Reads of addresses 8 and 9 and of unmapped addresses (11 and above) return 0.
- R10: Writes to the status address or to unmapped addresses change neither the lock state nor any configuration word.
- R11: A correct first key written while OPEN enters ARMED, which relocks the bank. Configuration writes between the two keys do not cancel the pending first key.
- R12: Configuration word i drives bits [32*i+31 : 32*i] of the mux output bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restores the lock |
| bus_addr | input | 5 | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_priv | input | 1 | Access is privileged; writes without it are ignored |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mux_sel | output | 256 | Stored configuration words, word i at bits 32*i upward |

## Verification
A write is captured on the rising edge where the strobe is high. The lock state, the status word and the stored words all change at that edge, so the mux output is due one cycle after the write is presented. Read data is combinational on the address and is due in the same cycle the address is presented. The scoreboard therefore queues each expected read or output value after the write that produces it. It presents the address one nanosecond after a rising edge and compares on the following falling edge, so no sample lands on a clock edge.

// File: rtl/pinmux_kl_pkg.sv
package pinmux_kl_pkg;

    // Unlock progress of the bank.
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_e;

    // What a decoded bus address points at.
    typedef enum logic [2:0] {
        TGT_MUX    = 3'd0,
        TGT_KEY_A  = 3'd1,
        TGT_KEY_B  = 3'd2,
        TGT_STATUS = 3'd3,
        TGT_NONE   = 3'd4
    } target_e;

    // Status word bit positions.
    localparam int STAT_LOCKED_BIT  = 0;
    localparam int STAT_PENDING_BIT = 1;

endpackage

// File: rtl/pinmux_kl_decode.sv
module pinmux_kl_decode
    import pinmux_kl_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 5,
    parameter int IDX_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           target,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] KEY_A_ADDR  = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] KEY_B_ADDR  = ADDR_W'(NUM_REGS + 1);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS + 2);

    always_comb begin
        idx    = addr[IDX_W-1:0];
        target = TGT_NONE;
        if (addr < KEY_A_ADDR) begin
            target = TGT_MUX;
        end else if (addr == KEY_A_ADDR) begin
            target = TGT_KEY_A;
        end else if (addr == KEY_B_ADDR) begin
            target = TGT_KEY_B;
        end else if (addr == STATUS_ADDR) begin
            target = TGT_STATUS;
        end
    end

endmodule

// File: rtl/pinmux_kl_seq.sv
module pinmux_kl_seq
    import pinmux_kl_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_a_wr,
    input  logic              kick_b_wr,
    input  logic [DATA_W-1:0] kick_data,
    output lock_state_e       state_q,
    output logic              bank_open,
    output logic              key_pending
);

    lock_state_e state_d;
    logic        first_ok;
    logic        second_ok;

    assign first_ok  = (kick_data == KEY_FIRST);
    assign second_ok = (kick_data == KEY_SECOND);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, open, relock, hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (kick_a_wr && first_ok) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (kick_a_wr) begin
                    state_d = first_ok ? ST_ARMED : ST_LOCKED;
                end else if (kick_b_wr) begin
                    state_d = second_ok ? ST_OPEN : ST_LOCKED;
                end
            end
            ST_OPEN: begin
                if (kick_a_wr) begin
                    state_d = first_ok ? ST_ARMED : ST_LOCKED;
                end else if (kick_b_wr && !second_ok) begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // Outputs.
    always_comb begin
        bank_open   = 1'b0;
        key_pending = 1'b0;
        unique case (state_q)
            ST_LOCKED: ;
            ST_ARMED:  key_pending = 1'b1;
            ST_OPEN:   bank_open   = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pinmux_kl_regs.sv
module pinmux_kl_regs #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_REGS*DATA_W-1:0]   q_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cell_q <= wr_data;
            end
        end

        assign q_flat[g*DATA_W +: DATA_W] = cell_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = q_flat[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/pinmux_keylock_bank.sv
module pinmux_keylock_bank
    import pinmux_kl_pkg::*;
#(
    parameter int                NUM_REGS   = 8,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 5,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'h95A4_F1E0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_priv,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] mux_sel
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    target_e           tgt;
    logic [IDX_W-1:0]  idx;
    logic              wr_ok;
    logic              kick_a_wr;
    logic              kick_b_wr;
    logic              cfg_wr;
    lock_state_e       seq_state;
    logic              bank_open;
    logic              key_pending;
    logic [DATA_W-1:0] cfg_rd;
    logic [DATA_W-1:0] status_word;

    pinmux_kl_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr   (bus_addr),
        .target (tgt),
        .idx    (idx)
    );

    assign wr_ok     = bus_we && bus_priv;
    assign kick_a_wr = wr_ok && (tgt == TGT_KEY_A);
    assign kick_b_wr = wr_ok && (tgt == TGT_KEY_B);
    assign cfg_wr    = wr_ok && (tgt == TGT_MUX) && bank_open;

    pinmux_kl_seq #(
        .DATA_W     (DATA_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_a_wr   (kick_a_wr),
        .kick_b_wr   (kick_b_wr),
        .kick_data   (bus_wdata),
        .state_q     (seq_state),
        .bank_open   (bank_open),
        .key_pending (key_pending)
    );

    pinmux_kl_regs #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .rd_idx  (idx),
        .rd_data (cfg_rd),
        .q_flat  (mux_sel)
    );

    always_comb begin
        status_word                   = '0;
        status_word[STAT_LOCKED_BIT]  = ~bank_open;
        status_word[STAT_PENDING_BIT] = key_pending;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (tgt)
            TGT_MUX:    bus_rdata = cfg_rd;
            TGT_STATUS: bus_rdata = status_word;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinmux_kl_chk.sv
module pinmux_kl_chk
    import pinmux_kl_pkg::*;
#(
    parameter int                NUM_REGS   = 8,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 5,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'h95A4_F1E0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_we,
    input logic                       bus_priv,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_REGS*DATA_W-1:0] mux_sel,
    input lock_state_e                state_q
);

    localparam logic [ADDR_W-1:0] KA_ADDR = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] KB_ADDR = ADDR_W'(NUM_REGS + 1);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(NUM_REGS + 2);

    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OPEN) |=> $stable(mux_sel));

    // R8
    unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_priv) |=> ($stable(mux_sel) && $stable(state_q)));

    // R4
    open_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && bus_we && bus_priv && bus_addr == KB_ADDR
         && bus_wdata == KEY_SECOND) |=> (state_q == ST_OPEN));

    // R6
    bad_first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_priv && bus_addr == KA_ADDR && bus_wdata != KEY_FIRST)
        |=> (state_q == ST_LOCKED));

    // R5
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q != ST_OPEN));

    // R9
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ST_ADDR) |->
        (bus_rdata[STAT_LOCKED_BIT] == (state_q != ST_OPEN)
         && bus_rdata[STAT_PENDING_BIT] == (state_q == ST_ARMED)));

endmodule

bind pinmux_keylock_bank pinmux_kl_chk #(
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .mux_sel   (mux_sel),
    .state_q   (seq_state)
);

// File: tb/pinmux_keylock_bank_test.sv
`timescale 1ns/1ps
module pinmux_keylock_bank_test;

    localparam int NREG = 8;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam logic [4:0]  A_KA = 5'd8;
    localparam logic [4:0]  A_KB = 5'd9;
    localparam logic [4:0]  A_ST = 5'd10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_priv = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NREG*32-1:0] mux_sel;

    int checks = 0;
    int errors = 0;
    logic mon_req = 1'b0;
    logic [31:0] exp_regs [NREG];

    typedef struct {
        bit          is_mux;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q [$];

    always #2 clk = ~clk;

    pinmux_keylock_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_priv  (bus_priv),
        .bus_rdata (bus_rdata),
        .mux_sel   (mux_sel)
    );

    // Monitor: pops expected items and compares away from the rising edge.
    always @(negedge clk) begin
        if (mon_req) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: no expected item queued");
            end else begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_mux ? mux_sel[it.sel*32 +: 32] : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: %s %0d actual %h expected %h",
                             it.tag, it.is_mux ? "mux word" : "read addr",
                             it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic p);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_priv = p;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_priv = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_mux = 1'b0; it.sel = int'(a); it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_addr = a; mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic expect_mux(input int i, input logic [31:0] e, input string tag);
        item_t it;
        it.is_mux = 1'b1; it.sel = i; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) exp_regs[i] = '0;
    endtask

    task automatic unlock();
        wr(A_KA, K0, 1'b1);
        wr(A_KB, K1, 1'b1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        do_reset();

        // R1 reset state
        expect_rd(A_ST, 32'h1, "R1");
        for (int i = 0; i < NREG; i++) expect_rd(5'(i), 32'h0, "R1");
        expect_mux(0, 32'h0, "R1");
        expect_mux(7, 32'h0, "R1");

        // R2 locked writes dropped
        wr(5'd2, 32'h0000_AAAA, 1'b1);
        expect_rd(5'd2, 32'h0, "R2");
        expect_mux(2, 32'h0, "R2");

        // R5 second key alone
        wr(A_KB, K1, 1'b1);
        expect_rd(A_ST, 32'h1, "R5");
        wr(5'd2, 32'h1234_5678, 1'b1);
        expect_rd(5'd2, 32'h0, "R5");

        // R3 first key arms, still locked
        wr(A_KA, K0, 1'b1);
        expect_rd(A_ST, 32'h3, "R3");
        wr(5'd3, 32'hDEAD_BEEF, 1'b1);
        expect_rd(5'd3, 32'h0, "R3");

        // R11 config write between keys keeps pending; R4 open
        wr(5'd1, 32'h5555_5555, 1'b1);
        expect_rd(A_ST, 32'h3, "R11");
        wr(A_KB, K1, 1'b1);
        expect_rd(A_ST, 32'h0, "R4");
        expect_rd(5'd1, 32'h0, "R2");

        // R4 / R12 writes take effect
        for (int i = 0; i < NREG; i++) begin
            exp_regs[i] = 32'hA500_0000 | (32'(i) << 8) | 32'(i * 3 + 1);
            wr(5'(i), exp_regs[i], 1'b1);
        end
        for (int i = 0; i < NREG; i++) expect_rd(5'(i), exp_regs[i], "R4");
        for (int i = 0; i < NREG; i++) expect_mux(i, exp_regs[i], "R12");

        // R8 unprivileged writes ignored
        wr(5'd0, 32'hFFFF_FFFF, 1'b0);
        expect_rd(5'd0, exp_regs[0], "R8");
        wr(A_KA, 32'h0, 1'b0);
        expect_rd(A_ST, 32'h0, "R8");

        // R9 reads of kick and unmapped addresses
        expect_rd(A_KA, 32'h0, "R9");
        expect_rd(A_KB, 32'h0, "R9");
        expect_rd(5'd15, 32'h0, "R9");

        // R10 writes to status / unmapped
        wr(A_ST, 32'hFFFF_FFFF, 1'b1);
        expect_rd(A_ST, 32'h0, "R10");
        wr(5'd20, 32'hFFFF_FFFF, 1'b1);
        expect_rd(A_ST, 32'h0, "R10");
        expect_rd(5'd4, exp_regs[4], "R10");

        // R7 wrong second key while open
        wr(A_KB, 32'h0000_0001, 1'b1);
        expect_rd(A_ST, 32'h1, "R7");
        wr(5'd0, 32'h0BAD_0BAD, 1'b1);
        expect_rd(5'd0, exp_regs[0], "R2");
        expect_mux(0, exp_regs[0], "R2");
        // R9 readable while locked
        expect_rd(5'd6, exp_regs[6], "R9");

        // R6 wrong first key clears pending
        wr(A_KA, K0, 1'b1);
        wr(A_KA, K1, 1'b1);
        expect_rd(A_ST, 32'h1, "R6");
        wr(A_KB, K1, 1'b1);
        expect_rd(A_ST, 32'h1, "R6");

        // R7 wrong second key while armed
        wr(A_KA, K0, 1'b1);
        wr(A_KB, K0, 1'b1);
        expect_rd(A_ST, 32'h1, "R7");

        // R11 first key while open relocks
        unlock();
        expect_rd(A_ST, 32'h0, "R4");
        wr(A_KA, K0, 1'b1);
        expect_rd(A_ST, 32'h3, "R11");
        wr(5'd5, 32'h7777_7777, 1'b1);
        expect_rd(5'd5, exp_regs[5], "R11");

        // R8 unprivileged key write from locked
        wr(A_KA, 32'h1, 1'b1);
        wr(A_KA, K0, 1'b0);
        expect_rd(A_ST, 32'h1, "R8");

        // R1 reset relocks and clears
        unlock();
        expect_rd(A_ST, 32'h0, "R4");
        do_reset();
        expect_rd(A_ST, 32'h1, "R1");
        expect_rd(5'd3, 32'h0, "R1");
        expect_mux(3, 32'h0, "R1");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule